// File: doc/BRIEF.md
# USB Device Event Interrupt Unit

This block gathers device-level USB bus events into one flag register and raises a single interrupt request toward the processor. Single-cycle event pulses from the bus logic each set their own flag. The events are upstream resume, end of resume, wake-up, end of bus reset and start of frame. A companion enable register selects which flags may drive the interrupt line.

A start-of-frame pulse that arrives with a frame-number CRC error sets the same start-of-frame flag. It also records the error in a separate qualifier output. Software reads that qualifier to tell an ordinary frame start from an erroneous one.

An internal idle timer watches a bus-activity input. When the bus has been quiet for the configured time, which defaults to 3 ms at a 250 MHz clock, the timer sets the suspend flag once. Software clears flags by writing zeros and programs the enables with a whole-byte write.

Top module: `usb_dev_evt_irq`

## Requirements
- R1: Flag positions in `flags_o`: suspend bit 0, start of frame bit 2, end of reset bit 3, wake-up bit 4, end of resume bit 5, upstream resume bit 6. An event pulse sets only its own bit, visible the cycle after the pulse.
- R2: Bits 1 and 7 of both `flags_o` and `ien_o` always read 0, whatever is written.
- R3: A write with `ien_wr_i` high loads `ien_wr_data_i` into the enable register. Each enable bit sits at the same position as the flag it gates.
- R4: `irq_o` is high exactly when some bit is set in both `flags_o` and `ien_o`.
- R5: A write with `flag_wr_i` high clears every flag whose data bit is 0. Flags whose data bit is 1 keep their value, so a write can never set a flag.
- R6: A hardware event in the same cycle as a software clear of that flag leaves the flag set.
- R7: On each start-of-frame pulse, `fn_err_o` takes the value of `sof_crc_err_i`. Outside such pulses it holds, so a CRC error input without a frame start has no effect.
- R8: The suspend flag sets exactly TICK_DIV*IDLE_TICKS cycles after the last clock cycle in which `bus_active_i` was high.
- R9: The suspend flag is raised only once per idle period. After software clears it, it stays clear until activity has been seen and a new full idle period has passed.
- R10: After reset, `flags_o`, `ien_o`, `fn_err_o` and `irq_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_up_resume_i | input | 1 | Upstream resume event pulse |
| ev_resume_end_i | input | 1 | End of resume event pulse |
| ev_wake_i | input | 1 | Wake-up event pulse |
| ev_reset_end_i | input | 1 | End of bus reset event pulse |
| ev_sof_i | input | 1 | Start of frame event pulse |
| sof_crc_err_i | input | 1 | Frame number of this SOF failed its CRC |
| bus_active_i | input | 1 | Bus activity seen this cycle |
| flag_wr_i | input | 1 | Flag register write strobe |
| flag_wr_data_i | input | 8 | Flag write data (0 clears) |
| ien_wr_i | input | 1 | Enable register write strobe |
| ien_wr_data_i | input | 8 | Enable write data |
| flags_o | output | 8 | Flag register |
| ien_o | output | 8 | Enable register |
| fn_err_o | output | 1 | Frame-number error qualifier |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach from the ports is the suspend path. The flag must first appear on exactly the right cycle, and then must not appear again during one long quiet stretch. The bench overrides the timer parameters to a short window. It ends activity on a known edge, samples one cycle before and one cycle at the expected count, and clears the flag. It then waits several more windows with the bus still quiet to show no second rise. Only after a fresh activity pulse does it expect the flag back.

// File: rtl/usb_evt_pkg.sv
package usb_evt_pkg;

    localparam int FLAG_W  = 8;
    localparam int B_SUSP  = 0;
    localparam int B_SOF   = 2;
    localparam int B_RSTE  = 3;
    localparam int B_WAKE  = 4;
    localparam int B_RSME  = 5;
    localparam int B_UPRS  = 6;

    // Implemented flag positions; the others are reserved and read as zero.
    localparam logic [FLAG_W-1:0] LIVE_MASK = 8'b0111_1101;

    typedef struct packed {
        logic up_resume;
        logic resume_end;
        logic wake;
        logic reset_end;
        logic sof;
        logic suspend;
    } evt_t;

    function automatic logic [FLAG_W-1:0] evt_to_vec(evt_t e);
        logic [FLAG_W-1:0] v;
        v         = '0;
        v[B_SUSP] = e.suspend;
        v[B_SOF]  = e.sof;
        v[B_RSTE] = e.reset_end;
        v[B_WAKE] = e.wake;
        v[B_RSME] = e.resume_end;
        v[B_UPRS] = e.up_resume;
        return v;
    endfunction

endpackage

// File: rtl/usb_idle_timer.sv
module usb_idle_timer #(
    parameter int TICK_DIV   = 250,
    parameter int IDLE_TICKS = 3000
) (
    input  logic clk,
    input  logic rst,
    input  logic bus_active_i,
    output logic fire_o
);
    localparam int PW = $clog2(TICK_DIV);
    localparam int CW = $clog2(IDLE_TICKS + 1);
    localparam logic [PW-1:0] PRE_LAST = PW'(TICK_DIV - 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(IDLE_TICKS - 1);

    logic [PW-1:0] pre_q;
    logic [CW-1:0] cnt_q;
    logic          armed_q;
    logic          tick;

    assign tick   = (pre_q == PRE_LAST);
    assign fire_o = tick && armed_q && (cnt_q == CNT_LAST) && !bus_active_i;

    always_ff @(posedge clk) begin
        if (rst || bus_active_i) begin
            pre_q   <= '0;
            cnt_q   <= '0;
            armed_q <= 1'b1;
        end else begin
            pre_q <= tick ? '0 : pre_q + 1'b1;
            if (tick && cnt_q != CNT_LAST)
                cnt_q <= cnt_q + 1'b1;
            if (fire_o)
                armed_q <= 1'b0;
        end
    end

    // R9
    single_fire_chk: assert property (@(posedge clk) disable iff (rst)
        fire_o |=> !fire_o);

    // R8
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        bus_active_i |=> (cnt_q == '0) && !fire_o);

endmodule

// File: rtl/usb_evt_flags.sv
module usb_evt_flags
    import usb_evt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  evt_t              set_i,
    input  logic              wr_i,
    input  logic [FLAG_W-1:0] wr_data_i,
    output logic [FLAG_W-1:0] flags_o
);
    logic [FLAG_W-1:0] set_vec;
    assign set_vec = evt_to_vec(set_i);

    for (genvar g = 0; g < FLAG_W; g++) begin : g_bit
        if (LIVE_MASK[g]) begin : g_live
            logic q;
            always_ff @(posedge clk) begin
                if (rst)
                    q <= 1'b0;
                else if (set_vec[g])
                    q <= 1'b1;
                else if (wr_i && !wr_data_i[g])
                    q <= 1'b0;
            end
            assign flags_o[g] = q;

            // R6
            set_wins_chk: assert property (@(posedge clk) disable iff (rst)
                set_vec[g] |=> flags_o[g]);

            // R5
            clear_chk: assert property (@(posedge clk) disable iff (rst)
                (wr_i && !wr_data_i[g] && !set_vec[g]) |=> !flags_o[g]);

            // R5
            hold_chk: assert property (@(posedge clk) disable iff (rst)
                (!set_vec[g] && !(wr_i && !wr_data_i[g])) |=> $stable(flags_o[g]));
        end else begin : g_rsvd
            assign flags_o[g] = 1'b0;
        end
    end

endmodule

// File: rtl/usb_dev_evt_irq.sv
module usb_dev_evt_irq
    import usb_evt_pkg::*;
#(
    parameter int TICK_DIV   = 250,
    parameter int IDLE_TICKS = 3000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ev_up_resume_i,
    input  logic       ev_resume_end_i,
    input  logic       ev_wake_i,
    input  logic       ev_reset_end_i,
    input  logic       ev_sof_i,
    input  logic       sof_crc_err_i,
    input  logic       bus_active_i,
    input  logic       flag_wr_i,
    input  logic [7:0] flag_wr_data_i,
    input  logic       ien_wr_i,
    input  logic [7:0] ien_wr_data_i,
    output logic [7:0] flags_o,
    output logic [7:0] ien_o,
    output logic       fn_err_o,
    output logic       irq_o
);
    logic susp_fire;
    evt_t evt;
    logic [FLAG_W-1:0] ien_q;
    logic fn_err_q;

    usb_idle_timer #(
        .TICK_DIV  (TICK_DIV),
        .IDLE_TICKS(IDLE_TICKS)
    ) u_idle (
        .clk         (clk),
        .rst         (rst),
        .bus_active_i(bus_active_i),
        .fire_o      (susp_fire)
    );

    always_comb begin
        evt.up_resume  = ev_up_resume_i;
        evt.resume_end = ev_resume_end_i;
        evt.wake       = ev_wake_i;
        evt.reset_end  = ev_reset_end_i;
        evt.sof        = ev_sof_i;
        evt.suspend    = susp_fire;
    end

    usb_evt_flags u_flags (
        .clk      (clk),
        .rst      (rst),
        .set_i    (evt),
        .wr_i     (flag_wr_i),
        .wr_data_i(flag_wr_data_i),
        .flags_o  (flags_o)
    );

    always_ff @(posedge clk) begin
        if (rst)
            ien_q <= '0;
        else if (ien_wr_i)
            ien_q <= ien_wr_data_i & LIVE_MASK;
    end

    always_ff @(posedge clk) begin
        if (rst)
            fn_err_q <= 1'b0;
        else if (ev_sof_i)
            fn_err_q <= sof_crc_err_i;
    end

    assign ien_o    = ien_q;
    assign fn_err_o = fn_err_q;
    assign irq_o    = |(flags_o & ien_q);

    // R7
    fn_err_load_chk: assert property (@(posedge clk) disable iff (rst)
        ev_sof_i |=> (fn_err_o == $past(sof_crc_err_i)));

    // R7
    fn_err_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ev_sof_i |=> $stable(fn_err_o));

    // R3
    ien_load_chk: assert property (@(posedge clk) disable iff (rst)
        ien_wr_i |=> (ien_o[6:2] == $past(ien_wr_data_i[6:2])) && (ien_o[0] == $past(ien_wr_data_i[0])));

endmodule

// File: tb/usb_dev_evt_irq_bench.sv
module usb_dev_evt_irq_bench;
    localparam int TD = 4;
    localparam int IT = 10;
    localparam int WIN = TD * IT;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ev_up_resume_i = 0, ev_resume_end_i = 0, ev_wake_i = 0, ev_reset_end_i = 0;
    logic ev_sof_i = 0, sof_crc_err_i = 0, bus_active_i = 1;
    logic flag_wr_i = 0, ien_wr_i = 0;
    logic [7:0] flag_wr_data_i = 8'hFF, ien_wr_data_i = 8'h00;
    logic [7:0] flags_o, ien_o;
    logic fn_err_o, irq_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    usb_dev_evt_irq #(.TICK_DIV(TD), .IDLE_TICKS(IT)) u_usb_dev_evt_irq (
        .clk(clk), .rst(rst),
        .ev_up_resume_i(ev_up_resume_i), .ev_resume_end_i(ev_resume_end_i),
        .ev_wake_i(ev_wake_i), .ev_reset_end_i(ev_reset_end_i),
        .ev_sof_i(ev_sof_i), .sof_crc_err_i(sof_crc_err_i),
        .bus_active_i(bus_active_i),
        .flag_wr_i(flag_wr_i), .flag_wr_data_i(flag_wr_data_i),
        .ien_wr_i(ien_wr_i), .ien_wr_data_i(ien_wr_data_i),
        .flags_o(flags_o), .ien_o(ien_o), .fn_err_o(fn_err_o), .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic pulse(input int which, input logic crc);
        case (which)
            6: ev_up_resume_i = 1;
            5: ev_resume_end_i = 1;
            4: ev_wake_i = 1;
            3: ev_reset_end_i = 1;
            default: begin ev_sof_i = 1; sof_crc_err_i = crc; end
        endcase
        step();
        {ev_up_resume_i, ev_resume_end_i, ev_wake_i, ev_reset_end_i, ev_sof_i, sof_crc_err_i} = '0;
    endtask

    task automatic wr_flags(input logic [7:0] d);
        flag_wr_i = 1; flag_wr_data_i = d; step(); flag_wr_i = 0; flag_wr_data_i = 8'hFF;
    endtask

    task automatic wr_ien(input logic [7:0] d);
        ien_wr_i = 1; ien_wr_data_i = d; step(); ien_wr_i = 0;
    endtask

    task automatic t_reset();
        chk("R10 flags", flags_o, 8'h00);
        chk("R10 ien", ien_o, 8'h00);
        chk("R10 fn_err", {7'b0, fn_err_o}, 8'h00);
        chk("R10 irq", {7'b0, irq_o}, 8'h00);
    endtask

    task automatic t_positions();
        for (int b = 2; b <= 6; b++) begin
            pulse(b, 1'b0);
            chk("R1 position", flags_o, 8'(1 << b));
            wr_flags(8'h00);
        end
    endtask

    task automatic t_reserved();
        wr_ien(8'hFF);
        chk("R2 ien reserved", ien_o, 8'h7D);
        wr_flags(8'hFF);
        chk("R2 flag write cannot set", flags_o, 8'h00);
        wr_ien(8'h00);
    endtask

    task automatic t_irq();
        wr_ien(8'h08);
        chk("R3 ien load", ien_o, 8'h08);
        pulse(4, 1'b0);
        chk("R4 disabled flag no irq", {7'b0, irq_o}, 8'h00);
        pulse(3, 1'b0);
        chk("R4 enabled flag irq", {7'b0, irq_o}, 8'h01);
        wr_flags(8'hF7);
        chk("R5 selective clear", flags_o, 8'h10);
        chk("R4 irq drops", {7'b0, irq_o}, 8'h00);
        wr_flags(8'h00);
        chk("R5 clear all", flags_o, 8'h00);
        wr_ien(8'h00);
    endtask

    task automatic t_priority();
        flag_wr_i = 1; flag_wr_data_i = 8'h00; ev_sof_i = 1;
        step();
        flag_wr_i = 0; flag_wr_data_i = 8'hFF; ev_sof_i = 0;
        chk("R6 set beats clear", flags_o, 8'h04);
        wr_flags(8'h00);
    endtask

    task automatic t_sof_err();
        pulse(2, 1'b1);
        chk("R7 sof err flag", flags_o, 8'h04);
        chk("R7 fn_err set", {7'b0, fn_err_o}, 8'h01);
        sof_crc_err_i = 0; step();
        chk("R7 fn_err holds", {7'b0, fn_err_o}, 8'h01);
        pulse(2, 1'b0);
        chk("R7 fn_err cleared by clean sof", {7'b0, fn_err_o}, 8'h00);
        sof_crc_err_i = 1; step(); sof_crc_err_i = 0;
        chk("R7 crc without sof ignored", {7'b0, fn_err_o}, 8'h00);
        wr_flags(8'h00);
    endtask

    task automatic t_suspend();
        wr_ien(8'h01);
        bus_active_i = 1; step();
        bus_active_i = 0;
        for (int i = 0; i < WIN - 1; i++) step();
        chk("R8 not yet suspended", flags_o, 8'h00);
        step();
        chk("R8 suspend at window", flags_o, 8'h01);
        chk("R4 suspend irq", {7'b0, irq_o}, 8'h01);
        wr_flags(8'h00);
        for (int i = 0; i < 3 * WIN; i++) step();
        chk("R9 no second suspend", flags_o, 8'h00);
        bus_active_i = 1; step(); bus_active_i = 0;
        for (int i = 0; i < WIN; i++) step();
        chk("R9 rearmed after activity", flags_o, 8'h01);
        bus_active_i = 1;
        wr_flags(8'h00);
        wr_ien(8'h00);
    endtask

    initial begin
        step(); step();
        rst = 0;
        step();
        t_reset();
        t_positions();
        t_reserved();
        t_irq();
        t_priority();
        t_sof_err();
        t_suspend();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule